// File: doc/BRIEF.md
# Serial Memory Bus Slave Command Decoder

This block is the byte-level slave front end of a two-wire serial memory. It watches the clock and data lines, which arrive already synchronised to the system clock. It finds bus Start and Stop conditions and shifts in the first byte of every transfer. That byte is checked against a fixed device code and three strap inputs. The block answers on the ninth clock by pulling the data line low. For a write it then gathers a two-byte word address and passes every following byte to the storage back end as a one-cycle strobe. For a read it fetches bytes from the back end and shifts them out most significant bit first.

The data line is open-drain. The block only asserts `sda_oe_o`, which tells the pad to pull the line low. While the back end reports a write cycle in progress on `busy_i`, no control byte is acknowledged. The array, pad timing and clock stretching belong to other blocks.

Top module: `i2c_mem_cmd_dec`

## Requirements
- R1: A control byte is acknowledged when its bits 7..4 equal the device code (binary 1010), its bits 3..1 equal `strap_i[2:0]` in order, and `busy_i` is low. The acknowledge holds the data line low for the whole ninth SCL high phase.
- R2: A control byte that fails the code or strap match gets no acknowledge. Every byte after it, up to the next Start, gets no acknowledge and raises no strobe.
- R3: If `busy_i` is high when the eighth bit of a control byte ends, the byte is not acknowledged, even when code and straps match.
- R4: Control byte bit 0 picks the operation: 0 starts a write (address bytes follow) and 1 starts a read (data is shifted out).
- R5: After a write control byte, two address bytes are taken high byte first and both are acknowledged. Bit 7 of the high byte is discarded. `addr_o` becomes {high[6:0], low[7:0]} and `addr_vld_o` pulses for one cycle.
- R6: Each byte after the address is acknowledged. It is presented on `wr_data_o` with a one-cycle `wr_strb_o` pulse, in the order received.
- R7: A Start at any point, including in the middle of a byte, clears the bit count. The block then takes the next byte as a fresh control byte.
- R8: A Stop releases the data line and returns the block to idle. `stop_strb_o` pulses once if the control byte of that transfer was acknowledged, and stays low otherwise.
- R9: In a read, `rd_data_i` is taken when the acknowledge clock ends, with a one-cycle `rd_strb_o` pulse. The byte is sent MSB first, each bit placed while SCL is low. Each master acknowledge fetches a further byte.
- R10: When the master does not acknowledge a read byte, the read ends. The data line stays released and no further byte is fetched until a Start or Stop.
- R11: Apart from reacting to a Start or Stop, the data line drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line (resolved level) |
| strap_i | input | 3 | Chip-select strap levels |
| busy_i | input | 1 | Back end internal write cycle in progress |
| rd_data_i | input | 8 | Next read byte from the back end |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| addr_o | output | 15 | Word address from the two address bytes |
| addr_vld_o | output | 1 | One-cycle pulse: `addr_o` updated |
| wr_strb_o | output | 1 | One-cycle pulse: write byte on `wr_data_o` |
| wr_data_o | output | 8 | Received write byte |
| rd_strb_o | output | 1 | One-cycle pulse: `rd_data_i` consumed |
| stop_strb_o | output | 1 | One-cycle pulse: Stop ended an acknowledged transfer |

## Verification
Every result is registered once behind the edge detector. The acknowledge drive, a write or address strobe, and a read byte load all appear one clock after the SCL fall that triggers them. The Stop pulse appears one clock after the data line rises with SCL high. The bench holds each SCL phase for four clocks. It reads the acknowledge and read bits in the middle of the SCL high phase, well after the drive has settled. Strobes are counted and logged on the falling clock edge and compared once the bus transfer is over, so the exact cycle of a pulse never decides a result.

// File: rtl/i2c_dec_pkg.sv
package i2c_dec_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 15;
    localparam int HI_W    = ADDR_W - BYTE_W;
    localparam int CNT_W   = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WDATA,
        ST_RDATA,
        ST_WAIT
    } dec_state_e;

    typedef struct packed {
        dec_state_e          state;
        logic [CNT_W-1:0]    cnt;
        logic                ack_ph;
        logic [BYTE_W-1:0]   shreg;
        logic                oe;
        logic                nack;
        logic [HI_W-1:0]     addr_hi;
        logic [ADDR_W-1:0]   addr;
        logic                addr_vld;
        logic                wr_strb;
        logic [BYTE_W-1:0]   wr_data;
        logic                rd_strb;
        logic                stop_strb;
    } dec_regs_t;
endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_ctrl_match.sv
module i2c_ctrl_match #(
    parameter int          STRAP_W  = 3,
    parameter int          CODE_W   = 8 - STRAP_W - 1,
    parameter logic [CODE_W-1:0] DEV_CODE = 4'b1010
) (
    input  logic [7:0]         ctrl_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    output logic               ack_o,
    output logic               read_o
);
    logic code_ok, strap_ok;

    assign code_ok  = (ctrl_i[7 -: CODE_W] == DEV_CODE);
    assign strap_ok = (ctrl_i[STRAP_W:1] == strap_i);
    assign ack_o    = code_ok & strap_ok & ~busy_i;
    assign read_o   = ctrl_i[0];
endmodule

// File: rtl/i2c_mem_cmd_dec.sv
module i2c_mem_cmd_dec
    import i2c_dec_pkg::*;
#(
    parameter int         STRAP_W  = 3,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic [STRAP_W-1:0]   strap_i,
    input  logic                 busy_i,
    input  logic [BYTE_W-1:0]    rd_data_i,
    output logic                 sda_oe_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic                 addr_vld_o,
    output logic                 wr_strb_o,
    output logic [BYTE_W-1:0]    wr_data_o,
    output logic                 rd_strb_o,
    output logic                 stop_strb_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic ctrl_ack, ctrl_rd;
    dec_regs_t q, d;

    i2c_line_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_ev),
        .stop_o    (stop_ev)
    );

    i2c_ctrl_match #(
        .STRAP_W (STRAP_W),
        .CODE_W  (4),
        .DEV_CODE(DEV_CODE)
    ) u_match (
        .ctrl_i (q.shreg),
        .strap_i(strap_i),
        .busy_i (busy_i),
        .ack_o  (ctrl_ack),
        .read_o (ctrl_rd)
    );

    always_comb begin
        d           = q;
        d.addr_vld  = 1'b0;
        d.wr_strb   = 1'b0;
        d.rd_strb   = 1'b0;
        d.stop_strb = 1'b0;
        if (stop_ev) begin
            d.stop_strb = (q.state != ST_IDLE) && (q.state != ST_CTRL);
            d.state     = ST_IDLE;
            d.oe        = 1'b0;
            d.cnt       = '0;
            d.ack_ph    = 1'b0;
        end else if (start_ev) begin
            d.state  = ST_CTRL;
            d.oe     = 1'b0;
            d.cnt    = '0;
            d.ack_ph = 1'b0;
        end else if (q.state != ST_IDLE && q.state != ST_WAIT) begin
            if (scl_rise) begin
                if (!q.ack_ph) begin
                    if (q.cnt != LAST_BIT) begin
                        d.cnt = q.cnt + 1'b1;
                        if (q.state != ST_RDATA) begin
                            d.shreg = {q.shreg[BYTE_W-2:0], sda_i};
                        end
                    end
                end else if (q.state == ST_RDATA) begin
                    d.nack = sda_i;
                end
            end else if (scl_fall) begin
                if (!q.ack_ph) begin
                    if (q.cnt == LAST_BIT) begin
                        d.ack_ph = 1'b1;
                        d.oe     = 1'b1;
                        unique case (q.state)
                            ST_CTRL: begin
                                if (!ctrl_ack) begin
                                    d.state  = ST_IDLE;
                                    d.oe     = 1'b0;
                                    d.ack_ph = 1'b0;
                                    d.cnt    = '0;
                                end
                            end
                            ST_ADDR_HI: d.addr_hi = q.shreg[HI_W-1:0];
                            ST_ADDR_LO: begin
                                d.addr     = {q.addr_hi, q.shreg};
                                d.addr_vld = 1'b1;
                            end
                            ST_WDATA: begin
                                d.wr_data = q.shreg;
                                d.wr_strb = 1'b1;
                            end
                            default: d.oe = 1'b0;
                        endcase
                    end else if (q.state == ST_RDATA && q.cnt != '0) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], 1'b0};
                        d.oe    = ~q.shreg[BYTE_W-2];
                    end
                end else begin
                    d.ack_ph = 1'b0;
                    d.cnt    = '0;
                    d.oe     = 1'b0;
                    unique case (q.state)
                        ST_CTRL: begin
                            if (ctrl_rd) begin
                                d.state   = ST_RDATA;
                                d.shreg   = rd_data_i;
                                d.oe      = ~rd_data_i[BYTE_W-1];
                                d.rd_strb = 1'b1;
                            end else begin
                                d.state = ST_ADDR_HI;
                            end
                        end
                        ST_ADDR_HI: d.state = ST_ADDR_LO;
                        ST_ADDR_LO: d.state = ST_WDATA;
                        ST_RDATA: begin
                            if (q.nack) begin
                                d.state = ST_WAIT;
                            end else begin
                                d.shreg   = rd_data_i;
                                d.oe      = ~rd_data_i[BYTE_W-1];
                                d.rd_strb = 1'b1;
                            end
                        end
                        default: d.state = q.state;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o    = q.oe;
    assign addr_o      = q.addr;
    assign addr_vld_o  = q.addr_vld;
    assign wr_strb_o   = q.wr_strb;
    assign wr_data_o   = q.wr_data;
    assign rd_strb_o   = q.rd_strb;
    assign stop_strb_o = q.stop_strb;

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_CTRL && busy_i && scl_fall && !q.ack_ph && q.cnt == LAST_BIT
         && !start_ev && !stop_ev) |=> !sda_oe_o); // R3
    AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (q.state == ST_CTRL && q.cnt == '0 && !sda_oe_o)); // R7
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (q.state == ST_IDLE && !sda_oe_o)); // R8
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe_o) && !$past(start_ev) && !$past(stop_ev)) |-> !$past(scl_i)); // R11
    AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_strb_o, addr_vld_o, rd_strb_o, stop_strb_o})); // R6
    AST_NACK_END: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RDATA && q.ack_ph && q.nack && scl_fall && !start_ev && !stop_ev)
        |=> (q.state == ST_WAIT && !sda_oe_o && !rd_strb_o)); // R10
    AST_ADDR_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld_o |-> $past(q.state == ST_ADDR_LO)); // R5
endmodule

// File: tb/i2c_mem_cmd_dec_bench.sv
module i2c_mem_cmd_dec_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] strap = 3'd0;
    logic busy = 1'b0;
    logic [7:0] rd_data;
    logic sda_oe, addr_vld, wr_strb, rd_strb, stop_strb;
    logic [14:0] addr;
    logic [7:0] wr_data;
    logic sda_line;

    int checks = 0;
    int fails = 0;
    int wr_cnt = 0, av_cnt = 0, rd_cnt = 0, st_cnt = 0;
    logic [7:0] wr_log [16];
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = 8'h5A ^ 8'(rd_cnt);

    i2c_mem_cmd_dec u_i2c_mem_cmd_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .busy_i     (busy),
        .rd_data_i  (rd_data),
        .sda_oe_o   (sda_oe),
        .addr_o     (addr),
        .addr_vld_o (addr_vld),
        .wr_strb_o  (wr_strb),
        .wr_data_o  (wr_data),
        .rd_strb_o  (rd_strb),
        .stop_strb_o(stop_strb)
    );

    always @(negedge clk) begin
        if (wr_strb) begin
            wr_log[wr_cnt[3:0]] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (addr_vld)  av_cnt <= av_cnt + 1;
        if (rd_strb)   rd_cnt <= rd_cnt + 1;
        if (stop_strb) st_cnt <= st_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b0; hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b1; hold();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; hold();
            scl_m = 1'b1; hold();
            scl_m = 1'b0;
        end
        hold();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        acked = ~sda_line;
        hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold();
            scl_m = 1'b1; hold();
            b[i] = sda_line;
            hold();
            scl_m = 1'b0;
        end
        hold();
        sda_m = ~give_ack; hold();
        scl_m = 1'b1; hold();
        scl_m = 1'b0; hold();
        sda_m = 1'b1;
    endtask

    // {ctrl[7:0], strap[2:0], busy, expected ack}
    localparam logic [12:0] VEC [7] = '{
        {8'hA0, 3'd0, 1'b0, 1'b1},
        {8'hA2, 3'd1, 1'b0, 1'b1},
        {8'hA2, 3'd0, 1'b0, 1'b0},
        {8'hB0, 3'd0, 1'b0, 1'b0},
        {8'hA0, 3'd0, 1'b1, 1'b0},
        {8'hAE, 3'd7, 1'b0, 1'b1},
        {8'h2E, 3'd7, 1'b0, 1'b0}
    };

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit a, a2, a3, a4;
        logic [7:0] rb0, rb1, rb2;
        int base_wr, base_av, base_st, base_rd;

        repeat (5) @(negedge clk);
        chk(!sda_oe && !wr_strb && !addr_vld && !rd_strb && !stop_strb, "R8 reset outputs idle",
            {sda_oe, wr_strb, addr_vld, rd_strb, stop_strb}, 0);
        rst_n = 1'b1;
        hold();

        // vector table: control byte decode, straps and busy
        for (int i = 0; i < 7; i++) begin
            logic [12:0] v;
            v = VEC[i];
            strap = v[4:2];
            busy  = v[1];
            base_st = st_cnt;
            bus_start();
            send_byte(v[12:5], a);
            bus_stop();
            hold();
            chk(a == v[0], $sformatf("R1/R3 ctrl ack vec%0d", i), a, v[0]);
            chk((st_cnt - base_st) == int'(v[0]), $sformatf("R8 stop strobe vec%0d", i),
                st_cnt - base_st, v[0]);
        end
        busy = 1'b0;
        strap = 3'd0;

        // write with address, top address bit discarded
        base_wr = wr_cnt; base_av = av_cnt; base_st = st_cnt;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'hC3, a2);
        send_byte(8'h5E, a3);
        chk(a && a2 && a3, "R5 address bytes acked", {a, a2, a3}, 3'b111);
        send_byte(8'h11, a);
        send_byte(8'h22, a2);
        chk(a && a2, "R6 data bytes acked", {a, a2}, 2'b11);
        bus_stop();
        hold();
        chk(addr == 15'h435E, "R4 R5 address value", addr, 15'h435E);
        chk(av_cnt - base_av == 1, "R5 one address pulse", av_cnt - base_av, 1);
        chk(wr_cnt - base_wr == 2, "R6 write strobe count", wr_cnt - base_wr, 2);
        chk(wr_log[base_wr[3:0]] == 8'h11 && wr_log[4'(base_wr + 1)] == 8'h22, "R6 write data order",
            {wr_log[base_wr[3:0]], wr_log[4'(base_wr + 1)]}, 16'h1122);
        chk(st_cnt - base_st == 1, "R8 stop after write", st_cnt - base_st, 1);

        // repeated start in the middle of a byte
        base_wr = wr_cnt; base_av = av_cnt;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h12, a2);
        send_bits(8'hFF, 3);
        bus_start();
        send_byte(8'hA0, a3);
        send_byte(8'h00, a);
        send_byte(8'h07, a);
        send_byte(8'h99, a4);
        bus_stop();
        hold();
        chk(a3 && a4, "R7 control after repeated start acked", {a3, a4}, 2'b11);
        chk(addr == 15'h0007, "R7 address after restart", addr, 15'h0007);
        chk(av_cnt - base_av == 1, "R7 no stale address pulse", av_cnt - base_av, 1);
        chk(wr_cnt - base_wr == 1 && wr_log[base_wr[3:0]] == 8'h99, "R7 write after restart",
            wr_cnt - base_wr, 1);

        // read: two bytes, master nack ends the read
        base_rd = rd_cnt; base_st = st_cnt;
        bus_start();
        send_byte(8'hA1, a);
        chk(a, "R4 read control acked", a, 1);
        read_byte(1'b1, rb0);
        read_byte(1'b0, rb1);
        chk(rb0 == (8'h5A ^ 8'(base_rd)), "R9 first read byte", rb0, 8'h5A ^ 8'(base_rd));
        chk(rb1 == (8'h5A ^ 8'(base_rd + 1)), "R9 second read byte", rb1, 8'h5A ^ 8'(base_rd + 1));
        read_byte(1'b0, rb2);
        chk(rb2 == 8'hFF, "R10 line released after nack", rb2, 8'hFF);
        chk(rd_cnt - base_rd == 2, "R10 no fetch after nack", rd_cnt - base_rd, 2);
        sda_m = 1'b0; hold();
        bus_stop();
        hold();
        chk(st_cnt - base_st == 1, "R8 stop after read", st_cnt - base_st, 1);

        // bytes after a rejected control byte are ignored
        base_wr = wr_cnt; base_av = av_cnt; base_st = st_cnt;
        bus_start();
        send_byte(8'hA4, a);
        send_byte(8'h00, a2);
        send_byte(8'h55, a3);
        send_byte(8'h66, a4);
        bus_stop();
        hold();
        chk(!a && !a2 && !a3 && !a4, "R2 no ack after mismatch", {a, a2, a3, a4}, 0);
        chk(wr_cnt == base_wr && av_cnt == base_av && st_cnt == base_st, "R2 no strobes",
            (wr_cnt - base_wr) + (av_cnt - base_av) + (st_cnt - base_st), 0);
        chk(addr == 15'h0007, "R2 address untouched", addr, 15'h0007);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule